// File: doc/BRIEF.md
# Pin Event Controller

A memory-mapped general-purpose I/O block with a 16-bit register bus and 48 pins arranged in three 16-bit banks. Software picks each pin's direction, writes an output latch and reads back either that latch (output pins) or the synchronised pad value (input pins). Every pin input passes through a two-stage synchroniser before anything else looks at it.

The lower 32 pins can each raise an interrupt. Per pin, software chooses edge or level triggering, the active level for level mode, and whether an edge event is held in the status bit until software clears it or only shows for the cycle it happens. Rising and falling edges are enabled separately; enabling both detects either edge. Status bits are cleared by writing ones. A pin whose status and enable bits are both 1 drives a single registered interrupt output that feeds an upstream interrupt controller.

Offsets are byte addresses. Each 32-bit function is split into a lower half (pins 0-15) and an upper half (pins 16-31) at consecutive even offsets: direction 0x00/0x02, data 0x04/0x06, status 0x08/0x0A, enable 0x0C/0x0E, trigger kind 0x10/0x12, active level 0x14/0x16, hold select 0x18/0x1A, falling enable 0x20/0x22, rising enable 0x24/0x26. Pins 32-47 have their data at 0x1C and their direction at 0x1E.

Top module: `gpio_event_unit`

## Requirements
- R1: While reset is asserted every register, including status and enable, reads zero, all output enables are 0 and the interrupt output is 0.
- R2: Direction bit 1 makes a pin an output: its output enable is 1 and its pad output equals its data latch; bit 0 makes it an input. Pins 32-47 take their direction from offset 0x1E.
- R3: A data read returns, per bit, the data latch for an output pin and the synchronised input for an input pin; a pad change is visible in the read two clock edges after it is applied.
- R4: With trigger kind 1 (edge) and hold bit 1, an enabled edge (rising enable at 0x24/0x26, falling enable at 0x20/0x22) sets the status bit and it stays set until a status write with a 1 in that bit; a written 0 leaves it unchanged.
- R5: With trigger kind 1 and hold bit 0, the status bit is 1 for exactly the cycle after each enabled edge is seen, and 0 otherwise.
- R6: With trigger kind 0 (level), the status bit is 1 whenever the synchronised pin equals its active-level bit (1 = active high, 0 = active low) and 0 otherwise; a clearing write has no lasting effect.
- R7: If an enabled edge event and a write-one clear hit a held status bit in the same cycle, the bit stays 1.
- R8: The interrupt output is registered and equals, one cycle later, the OR over the 32 interrupt pins of status AND enable.
- R9: Reads of any unused or odd offset return zero and writes to them change no register.
- R10: A configuration write takes effect from the next cycle and a status clear written in the very next cycle takes effect immediately, so a pin switched from level to held edge can be cleared right after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset (combinational) |
| pin_in | input | 48 | Pad input values, asynchronous |
| pin_out | output | 48 | Pad output values (data latch) |
| pin_oe | output | 48 | Pad output enables (direction) |
| irq_out | output | 1 | Registered cascade interrupt |

## Verification
A wrong synchroniser or edge-history flop shows up as a status bit set one cycle early or late, visible at the next status read and one cycle later on the interrupt output. A corrupted held status bit stays visible on every later status read until cleared, and, when enabled, keeps the interrupt output wrong from the next cycle on. Configuration or data latch errors appear immediately on the pad outputs or on the next read of that offset; the bench reads the register being exercised every cycle, so most faults surface within one to three clocks of their cause.

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [3*DW-1:0] pin_in,
  output logic [3*DW-1:0] pin_out,
  output logic [3*DW-1:0] pin_oe,
  output logic          irq_out
);
  localparam int NP = 3 * DW;
  localparam int NI = 2 * DW;

  localparam logic [AW-1:0] O_DIR0 = AW'('h00), O_DIR1 = AW'('h02), O_DIR2 = AW'('h1E);
  localparam logic [AW-1:0] O_DAT0 = AW'('h04), O_DAT1 = AW'('h06), O_DAT2 = AW'('h1C);
  localparam logic [AW-1:0] O_STS0 = AW'('h08), O_STS1 = AW'('h0A);
  localparam logic [AW-1:0] O_IEN0 = AW'('h0C), O_IEN1 = AW'('h0E);
  localparam logic [AW-1:0] O_TRG0 = AW'('h10), O_TRG1 = AW'('h12);
  localparam logic [AW-1:0] O_POL0 = AW'('h14), O_POL1 = AW'('h16);
  localparam logic [AW-1:0] O_HLD0 = AW'('h18), O_HLD1 = AW'('h1A);
  localparam logic [AW-1:0] O_FEN0 = AW'('h20), O_FEN1 = AW'('h22);
  localparam logic [AW-1:0] O_REN0 = AW'('h24), O_REN1 = AW'('h26);

  logic [NP-1:0] dir, dat, sy1, sy2;
  logic [NI-1:0] ien, trg, pol, hld, fen, ren, sts, prv;
  logic          irq_q;

  logic [NI-1:0] smp, evt, lvl, clr, sts_n;
  logic [NP-1:0] pad_view;

  assign smp = sy2[NI-1:0];
  assign evt = (smp & ~prv & ren) | (~smp & prv & fen);
  assign lvl = ~(smp ^ pol);
  assign clr = !bus_wr ? '0 :
               (bus_addr == O_STS0) ? {{DW{1'b0}}, bus_wdata} :
               (bus_addr == O_STS1) ? {bus_wdata, {DW{1'b0}}} : '0;
  assign sts_n = (~trg & lvl) | (trg & ~hld & evt) | (trg & hld & (evt | (sts & ~clr)));

  assign pad_view = (dir & dat) | (~dir & sy2);
  assign pin_out  = dat;
  assign pin_oe   = dir;
  assign irq_out  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1   <= '0;
      sy2   <= '0;
      prv   <= '0;
      sts   <= '0;
      irq_q <= 1'b0;
    end else begin
      sy1   <= pin_in;
      sy2   <= sy1;
      prv   <= smp;
      sts   <= sts_n;
      irq_q <= |(sts & ien);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0;
      dat <= '0;
      ien <= '0;
      trg <= '0;
      pol <= '0;
      hld <= '0;
      fen <= '0;
      ren <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        O_DIR0: dir[DW-1:0]      <= bus_wdata;
        O_DIR1: dir[2*DW-1:DW]   <= bus_wdata;
        O_DIR2: dir[3*DW-1:2*DW] <= bus_wdata;
        O_DAT0: dat[DW-1:0]      <= bus_wdata;
        O_DAT1: dat[2*DW-1:DW]   <= bus_wdata;
        O_DAT2: dat[3*DW-1:2*DW] <= bus_wdata;
        O_IEN0: ien[DW-1:0]      <= bus_wdata;
        O_IEN1: ien[2*DW-1:DW]   <= bus_wdata;
        O_TRG0: trg[DW-1:0]      <= bus_wdata;
        O_TRG1: trg[2*DW-1:DW]   <= bus_wdata;
        O_POL0: pol[DW-1:0]      <= bus_wdata;
        O_POL1: pol[2*DW-1:DW]   <= bus_wdata;
        O_HLD0: hld[DW-1:0]      <= bus_wdata;
        O_HLD1: hld[2*DW-1:DW]   <= bus_wdata;
        O_FEN0: fen[DW-1:0]      <= bus_wdata;
        O_FEN1: fen[2*DW-1:DW]   <= bus_wdata;
        O_REN0: ren[DW-1:0]      <= bus_wdata;
        O_REN1: ren[2*DW-1:DW]   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      O_DIR0: bus_rdata = dir[DW-1:0];
      O_DIR1: bus_rdata = dir[2*DW-1:DW];
      O_DIR2: bus_rdata = dir[3*DW-1:2*DW];
      O_DAT0: bus_rdata = pad_view[DW-1:0];
      O_DAT1: bus_rdata = pad_view[2*DW-1:DW];
      O_DAT2: bus_rdata = pad_view[3*DW-1:2*DW];
      O_STS0: bus_rdata = sts[DW-1:0];
      O_STS1: bus_rdata = sts[2*DW-1:DW];
      O_IEN0: bus_rdata = ien[DW-1:0];
      O_IEN1: bus_rdata = ien[2*DW-1:DW];
      O_TRG0: bus_rdata = trg[DW-1:0];
      O_TRG1: bus_rdata = trg[2*DW-1:DW];
      O_POL0: bus_rdata = pol[DW-1:0];
      O_POL1: bus_rdata = pol[2*DW-1:DW];
      O_HLD0: bus_rdata = hld[DW-1:0];
      O_HLD1: bus_rdata = hld[2*DW-1:DW];
      O_FEN0: bus_rdata = fen[DW-1:0];
      O_FEN1: bus_rdata = fen[2*DW-1:DW];
      O_REN0: bus_rdata = ren[DW-1:0];
      O_REN1: bus_rdata = ren[2*DW-1:DW];
      default: bus_rdata = '0;
    endcase
  end

  a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |=> !irq_out);
  a_r8_irq_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(ien != '0));

  for (genvar i = 0; i < NI; i++) begin : g_chk
    a_r4_held_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (trg[i] && hld[i] && sts[i] && !clr[i]) |=> sts[i]);
    a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (trg[i] && hld[i] && evt[i]) |=> sts[i]);
    a_r5_through_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (trg[i] && !hld[i] && !evt[i]) |=> !sts[i]);
    a_r6_level_inactive_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!trg[i] && (smp[i] != pol[i])) |=> !sts[i]);
  end
endmodule

// File: tb/test_gpio_event_unit.sv
module test_gpio_event_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out, pin_oe;
  logic        irq_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  gpio_event_unit i_gpio_event_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out));

  // behavioural reference model
  bit [47:0] m_dir, m_dat, m_s1, m_s2;
  bit [31:0] m_ien, m_trg, m_pol, m_hld, m_fen, m_ren, m_sts, m_prev;
  bit        m_irq;

  task automatic put16(inout bit [47:0] v, input int bank, input bit [15:0] d);
    for (int b = 0; b < 16; b++) v[bank*16+b] = d[b];
  endtask
  task automatic put32(inout bit [31:0] v, input int bank, input bit [15:0] d);
    for (int b = 0; b < 16; b++) v[bank*16+b] = d[b];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_dat = '0; m_s1 = '0; m_s2 = '0; m_ien = '0; m_trg = '0;
      m_pol = '0; m_hld = '0; m_fen = '0; m_ren = '0; m_sts = '0; m_prev = '0; m_irq = 0;
    end else begin
      bit nirq;
      bit [31:0] nsts;
      nirq = 0;
      for (int i = 0; i < 32; i++) begin
        bit up, dn, ev, wipe;
        if (m_sts[i] && m_ien[i]) nirq = 1;
        up = m_s2[i] && !m_prev[i];
        dn = !m_s2[i] && m_prev[i];
        ev = (up && m_ren[i]) || (dn && m_fen[i]);
        wipe = bus_wr && ((bus_addr == 6'h08 && i < 16 && bus_wdata[i % 16]) ||
                          (bus_addr == 6'h0A && i >= 16 && bus_wdata[i % 16]));
        if (!m_trg[i]) nsts[i] = (m_s2[i] == m_pol[i]);
        else if (!m_hld[i]) nsts[i] = ev;
        else nsts[i] = ev || (m_sts[i] && !wipe);
      end
      if (bus_wr) begin
        case (bus_addr)
          6'h00: put16(m_dir, 0, bus_wdata);
          6'h02: put16(m_dir, 1, bus_wdata);
          6'h1E: put16(m_dir, 2, bus_wdata);
          6'h04: put16(m_dat, 0, bus_wdata);
          6'h06: put16(m_dat, 1, bus_wdata);
          6'h1C: put16(m_dat, 2, bus_wdata);
          6'h0C: put32(m_ien, 0, bus_wdata);
          6'h0E: put32(m_ien, 1, bus_wdata);
          6'h10: put32(m_trg, 0, bus_wdata);
          6'h12: put32(m_trg, 1, bus_wdata);
          6'h14: put32(m_pol, 0, bus_wdata);
          6'h16: put32(m_pol, 1, bus_wdata);
          6'h18: put32(m_hld, 0, bus_wdata);
          6'h1A: put32(m_hld, 1, bus_wdata);
          6'h20: put32(m_fen, 0, bus_wdata);
          6'h22: put32(m_fen, 1, bus_wdata);
          6'h24: put32(m_ren, 0, bus_wdata);
          6'h26: put32(m_ren, 1, bus_wdata);
          default: ;
        endcase
      end
      m_prev = m_s2[31:0];
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_sts = nsts;
      m_irq = nirq;
    end
  end

  function automatic bit [15:0] expect_rd(input bit [5:0] a);
    bit [47:0] view;
    for (int i = 0; i < 48; i++) view[i] = m_dir[i] ? m_dat[i] : m_s2[i];
    case (a)
      6'h00: return m_dir[15:0];   6'h02: return m_dir[31:16];  6'h1E: return m_dir[47:32];
      6'h04: return view[15:0];    6'h06: return view[31:16];   6'h1C: return view[47:32];
      6'h08: return m_sts[15:0];   6'h0A: return m_sts[31:16];
      6'h0C: return m_ien[15:0];   6'h0E: return m_ien[31:16];
      6'h10: return m_trg[15:0];   6'h12: return m_trg[31:16];
      6'h14: return m_pol[15:0];   6'h16: return m_pol[31:16];
      6'h18: return m_hld[15:0];   6'h1A: return m_hld[31:16];
      6'h20: return m_fen[15:0];   6'h22: return m_fen[31:16];
      6'h24: return m_ren[15:0];   6'h26: return m_ren[31:16];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step();
    bit [15:0] er;
    @(negedge clk);
    vectors++;
    er = expect_rd(bus_addr);
    if (bus_rdata !== er) begin
      miscompares++;
      $display("FAIL %s read @%02h: got %04h expected %04h", tag, bus_addr, bus_rdata, er);
    end
    if (pin_out !== m_dat || pin_oe !== m_dir) begin
      miscompares++;
      $display("FAIL R2 pads: got out %012h oe %012h expected out %012h oe %012h",
               pin_out, pin_oe, m_dat, m_dir);
    end
    if (irq_out !== m_irq) begin
      miscompares++;
      $display("FAIL R8 irq_out (%s): got %0b expected %0b", tag, irq_out, m_irq);
    end
  endtask

  task automatic wr(input bit [5:0] a, input bit [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(input bit [5:0] a, input int n);
    bus_addr = a;
    repeat (n) step();
  endtask

  initial begin
    bit [5:0] legal [20] = '{6'h00, 6'h02, 6'h1E, 6'h04, 6'h06, 6'h1C, 6'h08, 6'h0A, 6'h0C, 6'h0E,
                             6'h10, 6'h12, 6'h14, 6'h16, 6'h18, 6'h1A, 6'h20, 6'h22, 6'h24, 6'h26};
    // R1: reset state
    tag = "R1";
    for (int a = 0; a < 64; a += 2) rd(6'(a), 1);
    rst_n = 1;
    rd(6'h08, 2);

    // R2: direction and pad drive
    tag = "R2";
    wr(6'h00, 16'hA5A5); wr(6'h04, 16'hFFFF); wr(6'h1E, 16'h00F0); wr(6'h1C, 16'h1234);
    rd(6'h00, 1); rd(6'h1E, 1); wr(6'h00, 16'h0000); rd(6'h00, 1);

    // R3: read-back of latch or synchronised pad
    tag = "R3";
    wr(6'h00, 16'h00FF);
    pin_in = 48'h5A5A_C3C3_F00F;
    rd(6'h04, 4);
    pin_in = 48'hFFFF_0000_0F0F;
    rd(6'h1C, 4); rd(6'h06, 3); rd(6'h04, 2);
    wr(6'h00, 16'h0000); wr(6'h1E, 16'h0000);

    // R9: unused offsets
    tag = "R9";
    rd(6'h28, 1); rd(6'h3E, 1); rd(6'h01, 1); rd(6'h09, 1);
    wr(6'h28, 16'hFFFF); wr(6'h3C, 16'hFFFF); wr(6'h0D, 16'hFFFF); wr(6'h2A, 16'hFFFF);
    rd(6'h0C, 1); rd(6'h00, 1); rd(6'h28, 1);

    // R4: held edge events and write-one clear
    tag = "R4";
    pin_in = '0;
    wr(6'h10, 16'hFFFF); wr(6'h18, 16'hFFFF); wr(6'h24, 16'h00FF); wr(6'h20, 16'hFF00);
    rd(6'h08, 3); wr(6'h08, 16'hFFFF);
    pin_in[15:0] = 16'hFFFF; rd(6'h08, 4);
    wr(6'h08, 16'h0000); rd(6'h08, 1);
    wr(6'h08, 16'h000F); rd(6'h08, 1);
    pin_in[15:0] = 16'h0000; rd(6'h08, 4);
    wr(6'h24, 16'hFFFF); wr(6'h20, 16'hFFFF); wr(6'h08, 16'hFFFF);
    pin_in[15:0] = 16'h0F0F; rd(6'h08, 4);

    // R5: through edge events
    tag = "R5";
    wr(6'h18, 16'h0000);
    pin_in[15:0] = 16'hF0F0; rd(6'h08, 5);
    pin_in[15:0] = 16'h0000; rd(6'h08, 5);

    // R6: level trigger with active-level select
    tag = "R6";
    wr(6'h12, 16'h0000); wr(6'h16, 16'h00FF);
    pin_in[31:16] = 16'h0F0F; rd(6'h0A, 4);
    wr(6'h0A, 16'hFFFF); rd(6'h0A, 2);
    pin_in[31:16] = 16'hF0F0; rd(6'h0A, 4);

    // R7: event and clear in the same cycle
    tag = "R7";
    wr(6'h18, 16'hFFFF); wr(6'h08, 16'hFFFF);
    pin_in[15:0] = 16'h0001;
    step(); step();
    wr(6'h08, 16'h0001); rd(6'h08, 2);

    // R8: cascade output
    tag = "R8";
    wr(6'h0C, 16'h0001); rd(6'h08, 3);
    wr(6'h08, 16'h0001); rd(6'h08, 2);
    wr(6'h0E, 16'h0F00); rd(6'h0A, 3);
    wr(6'h0E, 16'h0000); wr(6'h0C, 16'h0000); rd(6'h0A, 2);

    // R10: switch a level pin to held edge, clear right after
    tag = "R10";
    wr(6'h16, 16'h0000); pin_in[31:16] = 16'h0000; rd(6'h0A, 4);
    wr(6'h1A, 16'hFFFF); wr(6'h12, 16'hFFFF); wr(6'h0A, 16'hFFFF); rd(6'h0A, 3);

    // mixed random traffic over all features
    tag = "mixed";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) pin_in = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      if ($urandom_range(0, 2) == 0) wr(legal[$urandom_range(0, 19)], 16'($urandom()));
      else rd(legal[$urandom_range(0, 19)], 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule